// File: doc/BRIEF.md
# Bass Boost Mode Change Sequencer

This block turns three mode-select lines into the gain setting of a bass-boost filter path. It lets that setting change only while the audio output is silent, so a switch between boost levels produces no click. Each select line is sampled once per audio sample. A new combination must be seen on two consecutive sample strobes before it counts as a real change.

Once a change is accepted, the sequencer asks an external attenuation ramp for a soft mute and waits until the ramp reports full attenuation. It then commits the new code and holds the mute for one more sample period. After that it releases the mute and waits one more sample period before it will start another change. If the output is already fully attenuated when the change is accepted, for instance because an outside mute is active, the code is committed at once and the mute wait is skipped. At reset the committed code is loaded straight from the select lines, with no sequencing.

Top module: `boost_mode_seq`

## Requirements
- R1: The committed 3-bit code (bit 2 = first select line, bit 1 = second, bit 0 = third) maps to `gain_db_o` values 18, 16, 14, 12, 10 and 6 for codes 0 to 5 with `boost_en_o` high. Codes 6 and 7 give `gain_db_o` = 0 and `boost_en_o` low.
- R2: While `rst_n` is low, the committed code follows `sel_i` and `mute_req_o` is low. After release, no sequencing takes place until the select lines change.
- R3: A select value is accepted only when it is sampled unchanged on two consecutive `fs_stb_i` strobes. A value seen on a single strobe leaves the committed code and `mute_req_o` unchanged.
- R4: When the accepted value differs from the committed code and `muted_i` is low, `mute_req_o` rises on the next clock. The committed code holds until `muted_i` is seen high.
- R5: While the mute request is pending, the committed code takes the accepted value on the clock after `muted_i` is first seen high, and not before.
- R6: After a commit, `mute_req_o` stays high until the next strobe and then falls. A new change is taken up no earlier than one strobe after that.
- R7: If `muted_i` is already high when an accepted value differs from the committed code, the code is committed on the next clock without passing through the muting wait.
- R8: A change on any single select line, including either of the first two lines alone, goes through the same debounce and commit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_stb_i | input | 1 | One-clock pulse per audio sample |
| sel_i | input | 3 | Mode-select lines, first line in bit 2 |
| muted_i | input | 1 | High when the attenuation ramp has reached full attenuation |
| gain_code_o | output | 3 | Committed mode code |
| gain_db_o | output | 5 | Boost gain of the committed code in dB |
| boost_en_o | output | 1 | High when the committed code selects a boost |
| mute_req_o | output | 1 | Soft-mute request to the attenuation ramp |

## Verification
The hardest case to reach is a change that is accepted while the output is already silent, because `muted_i` normally rises only in answer to the block's own request. The bench drives `muted_i` from a small ramp model that counts strobes toward full attenuation whenever either the block or a bench-controlled outside mute asks for it. With the outside mute held long enough to saturate the ramp, select changes take the skip path, and a full sweep of all eight codes runs that way. Single-strobe glitches are produced by holding a new select value for fewer clocks than two strobe periods.

// File: rtl/bms_pkg.sv
package bms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_MUTING   = 2'd1,
    ST_APPLY    = 2'd2,
    ST_UNMUTING = 2'd3
  } seq_state_e;

  // Boost in dB for a committed mode code: 2 dB steps down from 18,
  // code 5 is the shallow 6 dB setting, the top pair disables boost.
  function automatic logic [4:0] code_to_db(input logic [2:0] code);
    logic [4:0] db;
    if (code <= 3'd4)      db = 5'd18 - {1'b0, code, 1'b0};
    else if (code == 3'd5) db = 5'd6;
    else                   db = 5'd0;
    return db;
  endfunction

  function automatic logic code_boosts(input logic [2:0] code);
    return code[2:1] != 2'b11;
  endfunction
endpackage

// File: rtl/mode_debounce.sv
module mode_debounce #(
  parameter int SEL_W        = 3,
  parameter int HOLD_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_stb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] acc_o
);
  localparam int CW = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_SAMPLES);
  localparam logic [CW-1:0] LAST_C = CW'(HOLD_SAMPLES - 1);

  logic [SEL_W-1:0] cand_q;
  logic [SEL_W-1:0] acc_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= sel_i;
      acc_q  <= sel_i;
      cnt_q  <= HOLD_C;
    end else if (fs_stb_i) begin
      if (sel_i != cand_q) begin
        cand_q <= sel_i;
        cnt_q  <= CW'(1);
      end else if (cnt_q < HOLD_C) begin
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == LAST_C) acc_q <= cand_q;
      end
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import bms_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_stb_i,
  input  logic             muted_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] acc_i,
  output logic [SEL_W-1:0] code_o,
  output logic             mute_req_o,
  output logic             commit_o
);
  seq_state_e       state_q, state_d;
  logic [SEL_W-1:0] code_q;
  logic             pending;

  assign pending  = acc_i != code_q;
  assign commit_o = ((state_q == ST_IDLE) && pending && muted_i) ||
                    ((state_q == ST_MUTING) && muted_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (pending) state_d = muted_i ? ST_APPLY : ST_MUTING;
      ST_MUTING:   if (muted_i) state_d = ST_APPLY;
      ST_APPLY:    if (fs_stb_i) state_d = ST_UNMUTING;
      ST_UNMUTING: if (fs_stb_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= sel_i;
    end else begin
      state_q <= state_d;
      if (commit_o) code_q <= acc_i;
    end
  end

  assign code_o     = code_q;
  assign mute_req_o = (state_q == ST_MUTING) || (state_q == ST_APPLY);
endmodule

// File: rtl/boost_mode_seq.sv
module boost_mode_seq
  import bms_pkg::*;
#(
  parameter int HOLD_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_stb_i,
  input  logic [2:0] sel_i,
  input  logic       muted_i,
  output logic [2:0] gain_code_o,
  output logic [4:0] gain_db_o,
  output logic       boost_en_o,
  output logic       mute_req_o
);
  localparam int SEL_W = 3;

  logic [SEL_W-1:0] acc_w;
  logic             commit_w;

  mode_debounce #(.SEL_W(SEL_W), .HOLD_SAMPLES(HOLD_SAMPLES)) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_stb_i (fs_stb_i),
    .sel_i    (sel_i),
    .acc_o    (acc_w)
  );

  mode_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_stb_i   (fs_stb_i),
    .muted_i    (muted_i),
    .sel_i      (sel_i),
    .acc_i      (acc_w),
    .code_o     (gain_code_o),
    .mute_req_o (mute_req_o),
    .commit_o   (commit_w)
  );

  assign gain_db_o  = code_to_db(gain_code_o);
  assign boost_en_o = code_boosts(gain_code_o);
endmodule

// File: rtl/boost_mode_seq_chk.sv
module boost_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_stb_i,
  input logic       muted_i,
  input logic [2:0] gain_code_o,
  input logic [4:0] gain_db_o,
  input logic       boost_en_o,
  input logic       mute_req_o,
  input logic [2:0] acc_w,
  input logic       commit_w
);
  // R1
  boost_gain_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boost_en_o == (gain_db_o != 5'd0));

  // R5
  commit_needs_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_code_o) |-> $past(muted_i));

  // R4
  mute_rise_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_req_o) |-> $past(acc_w != gain_code_o));

  // R6
  mute_drop_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_req_o) |-> $past(fs_stb_i));

  // R6
  hold_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> mute_req_o);

  // R3
  commit_value_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> (gain_code_o == $past(acc_w)));
endmodule

bind boost_mode_seq boost_mode_seq_chk u_chk (.*);

// File: tb/tb_boost_mode_seq.sv
module tb_boost_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs_stb_i = 1'b0;
  logic [2:0] sel_i = 3'b010;
  logic       muted_i = 1'b0;
  logic [2:0] gain_code_o;
  logic [4:0] gain_db_o;
  logic       boost_en_o;
  logic       mute_req_o;

  always #2 clk = ~clk;

  boost_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .fs_stb_i(fs_stb_i), .sel_i(sel_i),
    .muted_i(muted_i), .gain_code_o(gain_code_o), .gain_db_o(gain_db_o),
    .boost_en_o(boost_en_o), .mute_req_o(mute_req_o)
  );

  int n_run = 0, n_fail = 0, cycles = 0, div = 0, ramp = 0;
  bit ext_mute = 1'b0, started = 1'b0;
  // reference model: phase 0 idle, 1 waiting for silence, 2 holding, 3 releasing
  int m_cand, m_acc, m_cnt, m_com, m_ph;

  function automatic int exp_db(int c);
    case (c)
      0: return 18; 1: return 16; 2: return 14;
      3: return 12; 4: return 10; 5: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    int s, old_acc, old_com;
    s = int'(sel_i);
    if (!rst_n) begin
      m_cand = s; m_acc = s; m_cnt = 2; m_com = s; m_ph = 0;
    end else begin
      old_acc = m_acc; old_com = m_com;
      if (fs_stb_i) begin
        if (s != m_cand) begin m_cand = s; m_cnt = 1; end
        else if (m_cnt < 2) begin
          m_cnt++;
          if (m_cnt == 2) m_acc = s;
        end
      end
      if (m_ph == 0 && old_acc != old_com) begin
        if (muted_i) begin m_ph = 2; m_com = old_acc; end
        else m_ph = 1;
      end else if (m_ph == 1 && muted_i) begin
        m_ph = 2; m_com = old_acc;
      end else if (m_ph == 2 && fs_stb_i) m_ph = 3;
      else if (m_ph == 3 && fs_stb_i) m_ph = 0;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog (all requirements)", cycles, 100000);
      summary();
    end
    if (started) begin
      chk(int'(gain_code_o) == m_com, "R5 gain_code", int'(gain_code_o), m_com);
      chk(int'(gain_db_o) == exp_db(m_com), "R1 gain_db", int'(gain_db_o), exp_db(m_com));
      chk(boost_en_o == (m_com < 6), "R1 boost_en", int'(boost_en_o), int'(m_com < 6));
      chk(mute_req_o == (m_ph == 1 || m_ph == 2), "R4/R6 mute_req",
          int'(mute_req_o), int'(m_ph == 1 || m_ph == 2));
    end
    div = (div + 1) % 4;
    fs_stb_i = (div == 0);
    if (fs_stb_i) begin
      if (mute_req_o || ext_mute) begin if (ramp < 6) ramp++; end
      else if (ramp > 0) ramp--;
    end
    muted_i = (ramp == 6);
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(gain_code_o == 3'b010, "R2 reset load", int'(gain_code_o), 2);
    chk(mute_req_o == 1'b0, "R2 no mute after reset", int'(mute_req_o), 0);

    sel_i = 3'b100;
    repeat (4) @(negedge clk);
    sel_i = 3'b010;
    repeat (40) @(negedge clk);
    chk(gain_code_o == 3'b010, "R3 glitch ignored", int'(gain_code_o), 2);
    chk(mute_req_o == 1'b0, "R3 glitch no mute", int'(mute_req_o), 0);

    sel_i = 3'b000;
    repeat (12) @(negedge clk);
    chk(mute_req_o == 1'b1, "R4 mute requested", int'(mute_req_o), 1);
    chk(gain_code_o == 3'b010, "R4 code held while muting", int'(gain_code_o), 2);
    repeat (150) @(negedge clk);
    chk(gain_code_o == 3'b000, "R5 R8 committed", int'(gain_code_o), 0);
    chk(mute_req_o == 1'b0, "R6 mute released", int'(mute_req_o), 0);

    sel_i = 3'b100;
    repeat (200) @(negedge clk);
    chk(gain_code_o == 3'b100, "R8 first line alone", int'(gain_code_o), 4);

    ext_mute = 1'b1;
    repeat (60) @(negedge clk);
    sel_i = 3'b101;
    repeat (16) @(negedge clk);
    chk(gain_code_o == 3'b101, "R7 skip path commit", int'(gain_code_o), 5);

    for (int c = 0; c < 8; c++) begin
      sel_i = 3'(c);
      repeat (40) @(negedge clk);
      chk(int'(gain_db_o) == exp_db(c), "R1 sweep gain", int'(gain_db_o), exp_db(c));
      chk(boost_en_o == (c < 6), "R1 sweep enable", int'(boost_en_o), int'(c < 6));
    end

    ext_mute = 1'b0;
    repeat (100) @(negedge clk);
    chk(mute_req_o == 1'b0, "R6 idle at end", int'(mute_req_o), 0);
    summary();
  end
endmodule